// File: doc/BRIEF.md
# Operand Address Generator for an 8-bit Microcontroller Core

This block turns the addressing information of one instruction into a memory address and a memory-space select. In register mode it combines the two bank-select bits of the status word with the 3-bit register field of the opcode. The result is a 5-bit internal data address. Bank 0 starts at 00h, and bank 3 with register 7 sits at 1Fh.

In indirect mode it first presents the register-file read address of R0 or R1 in the active bank. The opcode's least significant bit picks which of the two. The byte returned on the read-data input then becomes the operand address.

In the two indexed modes it adds the unsigned accumulator to a 16-bit base, either the data pointer or the program counter. The sum wraps modulo 65536 and addresses program memory. That space is read-only, so any write request made in an indexed mode is refused.

The sequencer raises `req_i` for one cycle with the mode and operands. The result appears on the registered outputs one clock later, marked by `valid_o`.

Top module: `opnd_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `valid_o`, `addr_o`, `prog_space_o`, `wr_en_o` and `wr_refused_o` are all zero.
- R2: Register mode (`mode_i` = 2'b00): one cycle after `req_i`, `addr_o` = status[4:3]×8 + `reg_field_i`. Bits 15..5 are zero and `prog_space_o` is 0.
- R3: Indirect mode (`mode_i` = 2'b01): `rf_raddr_o` shows status[4:3]×8 + `reg_field_i[0]` in the same cycle. One cycle after `req_i`, `addr_o` is the zero-extended `rf_rdata_i` from the request cycle, and `prog_space_o` is 0.
- R4: Indexed-from-pointer mode (`mode_i` = 2'b10): one cycle after `req_i`, `addr_o` = (`dptr_i` + `acc_i`) mod 65536, and `prog_space_o` is 1. For example, 1E73h + 3Ah gives 1EADh.
- R5: Indexed-from-counter mode (`mode_i` = 2'b11): one cycle after `req_i`, `addr_o` = (`pc_i` + `acc_i`) mod 65536, and `prog_space_o` is 1.
- R6: A write request (`wr_req_i` = 1) in either indexed mode is refused. `wr_en_o` is 0, and `wr_refused_o` equals `wr_req_i`.
- R7: In register and indirect modes, `wr_en_o` equals `wr_req_i` and `wr_refused_o` is 0.
- R8: A cycle without `req_i` gives `valid_o` = 0 one cycle later. `addr_o`, `prog_space_o`, `wr_en_o` and `wr_refused_o` keep their values.
- R9: Status word bits other than 4 and 3 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Address request strobe |
| mode_i | input | 2 | 00 register, 01 indirect, 10 indexed from pointer, 11 indexed from counter |
| wr_req_i | input | 1 | The instruction wants to write its operand |
| reg_field_i | input | 3 | Register field from the opcode |
| status_i | input | 8 | Status word; bits 4:3 select the bank |
| acc_i | input | 8 | Accumulator (unsigned index) |
| dptr_i | input | 16 | Data pointer base |
| pc_i | input | 16 | Program counter base |
| rf_rdata_i | input | 8 | Register file read data for `rf_raddr_o` |
| rf_raddr_o | output | 5 | Register file read address for the pointer register |
| valid_o | output | 1 | Result valid |
| addr_o | output | 16 | Operand address |
| prog_space_o | output | 1 | 1 = program memory, 0 = internal data memory |
| wr_en_o | output | 1 | Write permitted |
| wr_refused_o | output | 1 | Write request rejected |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit data path, a 3-bit register field and the bank field at status bit 3. These defaults give all four banks and all eight registers. The sums of full-range bases and accumulators also reach the wrap beyond FFFFh. Random status words flip the bits outside the bank field, so any dependence on them shows up. The bench's model register file returns a value per address, so it exposes any wrong bank or pointer-register choice.

// File: rtl/opnd_addr_pkg.sv
package opnd_addr_pkg;
    typedef enum logic [1:0] {
        MODE_REG    = 2'b00,
        MODE_IND    = 2'b01,
        MODE_IDX_DP = 2'b10,
        MODE_IDX_PC = 2'b11
    } addr_mode_e;
endpackage

// File: rtl/opnd_bank_addr.sv
module opnd_bank_addr #(
    parameter int BANK_W = 2,
    parameter int REG_W  = 3,
    localparam int RA_W  = BANK_W + REG_W
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic [REG_W-1:0]  field_i,
    output logic [RA_W-1:0]   reg_addr_o,
    output logic [RA_W-1:0]   ptr_addr_o
);
    // bank * 2^REG_W + register number
    assign reg_addr_o = {bank_i, field_i};
    // pointer registers are the lowest two of the bank
    assign ptr_addr_o = {bank_i, {(REG_W-1){1'b0}}, field_i[0]};
endmodule

// File: rtl/opnd_idx_adder.sv
module opnd_idx_adder #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DATA_W-1:0] index_i,
    output logic [ADDR_W-1:0] sum_o
);
    // unsigned index, result truncated to ADDR_W bits (wraps)
    assign sum_o = base_i + ADDR_W'(index_i);
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
    import opnd_addr_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int REG_W    = 3,
    parameter int BANK_W   = 2,
    parameter int BANK_LSB = 3,
    localparam int RA_W    = BANK_W + REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [1:0]        mode_i,
    input  logic              wr_req_i,
    input  logic [REG_W-1:0]  reg_field_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [ADDR_W-1:0] dptr_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] rf_rdata_i,
    output logic [RA_W-1:0]   rf_raddr_o,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              prog_space_o,
    output logic              wr_en_o,
    output logic              wr_refused_o
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              prog;
        logic              wr_en;
        logic              refused;
    } out_state_t;

    out_state_t state_d, state_q;
    addr_mode_e mode;
    logic [BANK_W-1:0] bank;
    logic [RA_W-1:0]   reg_addr, ptr_addr;
    logic [ADDR_W-1:0] base, idx_sum;

    assign mode = addr_mode_e'(mode_i);
    assign bank = status_i[BANK_LSB +: BANK_W];
    assign base = (mode == MODE_IDX_PC) ? pc_i : dptr_i;

    opnd_bank_addr #(.BANK_W(BANK_W), .REG_W(REG_W)) i_bank (
        .bank_i    (bank),
        .field_i   (reg_field_i),
        .reg_addr_o(reg_addr),
        .ptr_addr_o(ptr_addr)
    );

    opnd_idx_adder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_idx (
        .base_i (base),
        .index_i(acc_i),
        .sum_o  (idx_sum)
    );

    assign rf_raddr_o = ptr_addr;

    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b0;
        if (req_i) begin
            state_d.valid = 1'b1;
            unique case (mode)
                MODE_REG: begin
                    state_d.addr    = ADDR_W'(reg_addr);
                    state_d.prog    = 1'b0;
                    state_d.wr_en   = wr_req_i;
                    state_d.refused = 1'b0;
                end
                MODE_IND: begin
                    state_d.addr    = ADDR_W'(rf_rdata_i);
                    state_d.prog    = 1'b0;
                    state_d.wr_en   = wr_req_i;
                    state_d.refused = 1'b0;
                end
                default: begin
                    state_d.addr    = idx_sum;
                    state_d.prog    = 1'b1;
                    state_d.wr_en   = 1'b0;
                    state_d.refused = wr_req_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign valid_o      = state_q.valid;
    assign addr_o       = state_q.addr;
    assign prog_space_o = state_q.prog;
    assign wr_en_o      = state_q.wr_en;
    assign wr_refused_o = state_q.refused;

    assert_reg_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(mode_i) == 2'b00) |->
            (addr_o == ADDR_W'({$past(status_i[BANK_LSB +: BANK_W]), $past(reg_field_i)}) && !prog_space_o));

    assert_idx_dptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(mode_i) == 2'b10) |->
            (addr_o == $past(dptr_i) + ADDR_W'($past(acc_i)) && prog_space_o));

    assert_idx_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(mode_i) == 2'b11) |->
            (addr_o == $past(pc_i) + ADDR_W'($past(acc_i)) && prog_space_o));

    assert_no_prog_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_space_o |-> !wr_en_o);

    assert_refuse_only_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && wr_refused_o) |-> ($past(mode_i[1]) && $past(wr_req_i)));

    assert_data_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !$past(mode_i[1])) |-> (wr_en_o == $past(wr_req_i) && !wr_refused_o));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(req_i) && $past(rst_n)) |-> (!valid_o && $stable(addr_o) && $stable(prog_space_o)));
endmodule

// File: tb/test_opnd_addr_gen.sv
module test_opnd_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic        wr_req_i = 1'b0;
    logic [2:0]  reg_field_i = '0;
    logic [7:0]  status_i = '0;
    logic [7:0]  acc_i = '0;
    logic [15:0] dptr_i = '0;
    logic [15:0] pc_i = '0;
    logic [7:0]  rf_rdata_i;
    logic [4:0]  rf_raddr_o;
    logic        valid_o, prog_space_o, wr_en_o, wr_refused_o;
    logic [15:0] addr_o;

    int vectors = 0;
    int fails = 0;

    always #4 clk = ~clk;

    // model register file: distinct byte per address
    function automatic logic [7:0] rf_model(input logic [4:0] a);
        return 8'(a * 8'd37 + 8'd11);
    endfunction
    assign rf_rdata_i = rf_model(rf_raddr_o);

    opnd_addr_gen i_opnd_addr_gen (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
        .wr_req_i(wr_req_i), .reg_field_i(reg_field_i), .status_i(status_i),
        .acc_i(acc_i), .dptr_i(dptr_i), .pc_i(pc_i), .rf_rdata_i(rf_rdata_i),
        .rf_raddr_o(rf_raddr_o), .valid_o(valid_o), .addr_o(addr_o),
        .prog_space_o(prog_space_o), .wr_en_o(wr_en_o), .wr_refused_o(wr_refused_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_addr(input logic [1:0] m, input logic [7:0] st,
                                              input logic [2:0] f, input logic [7:0] a,
                                              input logic [15:0] dp, input logic [15:0] p);
        logic [4:0] ptr;
        ptr = 5'(st[4:3] * 8 + f[0]);
        case (m)
            2'b00:   return 16'(st[4:3] * 8 + f);
            2'b01:   return {8'h00, rf_model(ptr)};
            2'b10:   return 16'(dp + a);
            default: return 16'(p + a);
        endcase
    endfunction

    task automatic apply(input logic [1:0] m, input logic w, input logic [2:0] f,
                         input logic [7:0] st, input logic [7:0] a,
                         input logic [15:0] dp, input logic [15:0] p);
        logic [15:0] ea;
        string tag;
        @(negedge clk);
        req_i = 1'b1; mode_i = m; wr_req_i = w; reg_field_i = f;
        status_i = st; acc_i = a; dptr_i = dp; pc_i = p;
        ea = exp_addr(m, st, f, a, dp, p);
        #1;
        if (m == 2'b01) check("R3 rf_raddr", 32'(rf_raddr_o), 32'(st[4:3] * 8 + f[0]));
        @(negedge clk);
        req_i = 1'b0;
        tag = (m == 2'b00) ? "R2" : (m == 2'b01) ? "R3" : (m == 2'b10) ? "R4" : "R5";
        check({tag, " valid"}, 32'(valid_o), 32'd1);
        check({tag, " R9 addr"}, 32'(addr_o), 32'(ea));
        check({tag, " space"}, 32'(prog_space_o), 32'(m[1]));
        if (m[1]) begin
            check("R6 wr_en", 32'(wr_en_o), 32'd0);
            check("R6 refused", 32'(wr_refused_o), 32'(w));
        end else begin
            check("R7 wr_en", 32'(wr_en_o), 32'(w));
            check("R7 refused", 32'(wr_refused_o), 32'd0);
        end
    endtask

    task automatic idle_hold;
        logic [15:0] a0;
        logic p0, w0, r0;
        a0 = addr_o; p0 = prog_space_o; w0 = wr_en_o; r0 = wr_refused_o;
        @(negedge clk);
        mode_i = 2'($urandom); acc_i = 8'($urandom); dptr_i = 16'($urandom);
        status_i = 8'($urandom); wr_req_i = 1'($urandom);
        @(negedge clk);
        check("R8 valid", 32'(valid_o), 32'd0);
        check("R8 addr", 32'(addr_o), 32'(a0));
        check("R8 flags", {29'd0, prog_space_o, wr_en_o, wr_refused_o}, {29'd0, p0, w0, r0});
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        #20;
        check("R1 reset", {27'd0, valid_o, prog_space_o, wr_en_o, wr_refused_o, 1'b0}, 32'd0);
        check("R1 reset addr", 32'(addr_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {27'd0, valid_o, prog_space_o, wr_en_o, wr_refused_o, 1'b0}, 32'd0);

        apply(2'b10, 1'b0, 3'd0, 8'h00, 8'h3A, 16'h1E73, 16'h0000); // R4 worked example
        check("R4 example", 32'(addr_o), 32'h1EAD);
        apply(2'b10, 1'b1, 3'd0, 8'h00, 8'h20, 16'hFFF0, 16'h0000); // R4 wrap, R6 refuse
        check("R4 wrap", 32'(addr_o), 32'h0010);
        apply(2'b11, 1'b1, 3'd0, 8'h00, 8'hFF, 16'h0000, 16'hFF01); // R5 wrap
        check("R5 wrap", 32'(addr_o), 32'h0000);
        apply(2'b00, 1'b1, 3'd7, 8'h18, 8'h00, 16'h0, 16'h0);       // R2 top register
        check("R2 bank3 r7", 32'(addr_o), 32'h001F);
        apply(2'b00, 1'b0, 3'd0, 8'hE7, 8'h00, 16'h0, 16'h0);       // R9 other bits set
        check("R9 bank0 r0", 32'(addr_o), 32'h0000);
        apply(2'b01, 1'b1, 3'd1, 8'h10, 8'h00, 16'h0, 16'h0);       // R3 bank2 R1
        idle_hold();

        for (int i = 0; i < 400; i++) begin
            apply(2'($urandom), 1'($urandom), 3'($urandom), 8'($urandom),
                  8'($urandom), 16'($urandom), 16'($urandom));
            if (($urandom % 5) == 0) idle_hold();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule